// File: doc/BRIEF.md
# PS/2 Keyboard Frame Receiver

This block takes the two open-collector lines of a PS/2 keyboard, clock and data, and returns whole received bytes in the system clock domain. The keyboard drives both lines, and both rest high. Each line goes through a two-flop synchronizer and then a stability filter. The block takes one data bit whenever the filtered keyboard clock falls. A frame has eleven bits: a low start bit, eight data bits with the least significant bit first, an odd parity bit, and a high stop bit.

A frame is not closed by its bit count alone. The block closes it once the filtered keyboard clock has stayed high for about 55 µs. At that point it checks the collected bits and then clears them. A frame that arrived cut short or with extra bits is therefore dropped, and the next frame starts from a clean state. When a frame passes every check, its byte is latched and a flag rises. The flag is cleared when the next frame begins.

The system clock frequency is a parameter and sets the length of the idle timeout. A second parameter gives the filter counter width N. Pick N so that 2^N system clocks last about 5 µs; for a 50 MHz clock, N is 8.

Top module: `ps2_frame_rx`

## Requirements
- R1: After reset, `code_byte` is 0x00 and `code_new` is 0.
- R2: A frame is accepted when four conditions hold: start bit 0, stop bit 1, an odd number of ones across the eight data bits and the parity bit, and exactly 11 falling clock edges. The data byte then appears on `code_byte` and `code_new` goes to 1.
- R3: The first data bit after the start bit lands in `code_byte[0]`, and the eighth lands in `code_byte[7]`.
- R4: A frame with even parity is dropped. `code_byte` keeps its earlier value and `code_new` does not rise.
- R5: A frame whose start bit is 1 is dropped, with the outputs behaving as in R4.
- R6: A frame whose stop bit is 0 is dropped, with the outputs behaving as in R4.
- R7: A frame with 10 or with 12 falling clock edges is dropped. The next well-formed frame is still received correctly.
- R8: `code_new` is 0 from the first falling clock edge of a frame until that frame closes.
- R9: A low pulse on the keyboard clock line that is shorter than the filter window is not counted as an edge.
- R10: A frame closes only after the filtered keyboard clock has stayed high for CLK_HZ/18000 system clocks. `code_new` does not rise earlier than that.
- R11: After a good frame, `code_byte` and `code_new` hold their values until the next frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ps2_clk_i | input | 1 | Keyboard clock line, asynchronous, idle high |
| ps2_dat_i | input | 1 | Keyboard data line, asynchronous, idle high |
| code_byte | output | 8 | Last byte received without error |
| code_new | output | 1 | High once a good byte is latched; cleared when the next frame starts |

## Verification
A shift register or bit counter that has drifted does not show up until the idle timeout expires. The symptom is then either a byte rotated by one position or a `code_new` that never rises. The directed frames therefore use asymmetric data, send the wrong number of edges, and always follow a dropped frame with a good one. A filter that passes glitches adds an edge, which shows at the ports as a lost frame. An idle counter that is too short closes a frame in the middle, which shows as `code_new` going low partway through a frame or rising too early. The bench samples for this both mid-frame and shortly after the last edge.

// File: rtl/ps2_rx_pkg.sv
package ps2_rx_pkg;
  localparam int FRAME_BITS = 11;
  localparam int CNT_W      = 4;
  localparam int BYTE_W     = 8;
  typedef logic [FRAME_BITS-1:0] frame_t;
  typedef logic [CNT_W-1:0]      bitcnt_t;
  localparam bitcnt_t CNT_FULL  = '1;
  localparam bitcnt_t CNT_FRAME = CNT_W'(FRAME_BITS);
endpackage

// File: rtl/ps2_line_filter.sv
module ps2_line_filter #(
  parameter int DEB_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);
  logic [1:0]       sync_q;
  logic [DEB_W-1:0] cnt_q, cnt_d;
  logic             line_q, line_d;
  logic             differ;

  assign differ = sync_q[1] ^ sync_q[0];

  always_comb begin
    cnt_d  = cnt_q;
    line_d = line_q;
    if (differ) begin
      cnt_d = '0;
    end else if (cnt_q != '1) begin
      cnt_d = cnt_q + 1'b1;
    end else begin
      line_d = sync_q[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      cnt_q  <= '0;
      line_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], line_i};
      cnt_q  <= cnt_d;
      line_q <= line_d;
    end
  end

  assign line_o = line_q;
endmodule

// File: rtl/ps2_frame_shift.sv
module ps2_frame_shift
  import ps2_rx_pkg::*;
#(
  parameter int IDLE_MAX = 2777
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    line_clk,
  input  logic    line_dat,
  output logic    fall_evt,
  output logic    frame_done,
  output frame_t  frame,
  output bitcnt_t bit_cnt
);
  localparam int IW = $clog2(IDLE_MAX + 1);
  localparam logic [IW-1:0] IDLE_LAST = IW'(IDLE_MAX - 1);

  logic          clk_prev_q;
  logic [IW-1:0] idle_q, idle_d;
  frame_t        sh_q, sh_d;
  bitcnt_t       cnt_q, cnt_d;
  logic          sh_en;

  assign fall_evt   = clk_prev_q & ~line_clk;
  assign frame_done = line_clk & (idle_q == IDLE_LAST);
  assign sh_en      = fall_evt | frame_done;

  always_comb begin
    idle_d = idle_q;
    if (!line_clk) begin
      idle_d = '0;
    end else if (idle_q != IW'(IDLE_MAX)) begin
      idle_d = idle_q + 1'b1;
    end
  end

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (frame_done) begin
      sh_d  = '0;
      cnt_d = '0;
    end else if (fall_evt) begin
      sh_d  = {line_dat, sh_q[FRAME_BITS-1:1]};
      cnt_d = (cnt_q == CNT_FULL) ? cnt_q : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_prev_q <= 1'b1;
      idle_q     <= '0;
    end else begin
      clk_prev_q <= line_clk;
      idle_q     <= idle_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (sh_en) begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

  assign frame   = sh_q;
  assign bit_cnt = cnt_q;
endmodule

// File: rtl/ps2_frame_check.sv
module ps2_frame_check
  import ps2_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall_evt,
  input  logic              frame_done,
  input  frame_t            frame,
  input  bitcnt_t           bit_cnt,
  output logic [BYTE_W-1:0] code_byte,
  output logic              code_new
);
  logic              good;
  logic              accept;
  logic [BYTE_W-1:0] byte_q, byte_d;
  logic              new_q, new_d;

  assign good = (bit_cnt == CNT_FRAME) && !frame[0] && frame[FRAME_BITS-1]
                && (^frame[BYTE_W+1:1]);
  assign accept = frame_done & good;

  always_comb begin
    byte_d = byte_q;
    new_d  = new_q;
    if (accept) begin
      byte_d = frame[BYTE_W:1];
      new_d  = 1'b1;
    end else if (fall_evt) begin
      new_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= '0;
      new_q  <= 1'b0;
    end else begin
      byte_q <= byte_d;
      new_q  <= new_d;
    end
  end

  assign code_byte = byte_q;
  assign code_new  = new_q;
endmodule

// File: rtl/ps2_frame_rx.sv
module ps2_frame_rx
  import ps2_rx_pkg::*;
#(
  parameter int CLK_HZ = 50_000_000,
  parameter int DEB_W  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ps2_clk_i,
  input  logic       ps2_dat_i,
  output logic [7:0] code_byte,
  output logic       code_new
);
  localparam int IDLE_RAW = CLK_HZ / 18000;
  localparam int IDLE_MAX = (IDLE_RAW < 2) ? 2 : IDLE_RAW;

  logic [1:0] rst_pipe;
  logic       rst_ns;
  logic [1:0] raw_lines;
  logic [1:0] filt_lines;
  logic       line_clk, line_dat;
  logic       fall_evt, frame_done;
  frame_t     frame;
  bitcnt_t    bit_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ns = rst_pipe[1];

  assign raw_lines = {ps2_dat_i, ps2_clk_i};

  for (genvar g = 0; g < 2; g++) begin : g_flt
    ps2_line_filter #(.DEB_W(DEB_W)) u_flt (
      .clk    (clk),
      .rst_n  (rst_ns),
      .line_i (raw_lines[g]),
      .line_o (filt_lines[g])
    );
  end

  assign line_clk = filt_lines[0];
  assign line_dat = filt_lines[1];

  ps2_frame_shift #(.IDLE_MAX(IDLE_MAX)) u_shift (
    .clk        (clk),
    .rst_n      (rst_ns),
    .line_clk   (line_clk),
    .line_dat   (line_dat),
    .fall_evt   (fall_evt),
    .frame_done (frame_done),
    .frame      (frame),
    .bit_cnt    (bit_cnt)
  );

  ps2_frame_check u_check (
    .clk        (clk),
    .rst_n      (rst_ns),
    .fall_evt   (fall_evt),
    .frame_done (frame_done),
    .frame      (frame),
    .bit_cnt    (bit_cnt),
    .code_byte  (code_byte),
    .code_new   (code_new)
  );
endmodule

// File: rtl/ps2_frame_rx_chk.sv
module ps2_frame_rx_chk
  import ps2_rx_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] code_byte,
  input logic       code_new,
  input logic       line_clk,
  input logic       frame_done,
  input frame_t     frame,
  input bitcnt_t    bit_cnt
);
  p_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !code_new);

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(code_new) |-> (!$past(frame[0]) && $past(frame[FRAME_BITS-1])
                          && (^$past(frame[9:1]))));

  p_byte_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code_byte) |-> $rose(code_new));

  p_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(code_new) |-> ($past(bit_cnt) == CNT_FRAME));

  p_low_in_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_clk) |=> !code_new);

  p_close_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(code_new) |-> $past(frame_done));
endmodule

bind ps2_frame_rx ps2_frame_rx_chk u_chk_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .code_byte  (code_byte),
  .code_new   (code_new),
  .line_clk   (line_clk),
  .frame_done (frame_done),
  .frame      (frame),
  .bit_cnt    (bit_cnt)
);

// File: tb/sim_ps2_frame_rx.sv
module sim_ps2_frame_rx;
  localparam int CLK_PERIOD = 10;
  localparam int HZ   = 1_000_000;
  localparam int DEBW = 2;

  logic       clk;
  logic       rst_n;
  logic       pclk, pdat;
  logic [7:0] code_byte;
  logic       code_new;
  int         checks;
  int         errors;
  logic [7:0] last;

  ps2_frame_rx #(.CLK_HZ(HZ), .DEB_W(DEBW)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .ps2_clk_i (pclk),
    .ps2_dat_i (pdat),
    .code_byte (code_byte),
    .code_new  (code_new)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s code_byte act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk1(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s code_new act=%b exp=%b", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] mk(input logic [7:0] d, input bit bad_start,
                                      input bit bad_par, input bit bad_stop);
    logic par;
    par = (~^d) ^ bad_par;
    return {1'b1, ~bad_stop, par, d, bad_start};
  endfunction

  // one bit: data set, 20 high, 40 low, 20 high; optional glitch on bit gl_at
  task automatic send_bits(input logic [11:0] bits, input int n, input int gl_at,
                           input bit mid_check);
    for (int i = 0; i < n; i++) begin
      pdat = bits[i];
      if (i == gl_at) begin
        cyc(8); pclk = 1'b0; cyc(2); pclk = 1'b1; cyc(10);
      end else begin
        cyc(20);
      end
      pclk = 1'b0;
      cyc(40);
      pclk = 1'b1;
      cyc(20);
      if (mid_check && i == 5) chk1("R8 mid-frame", code_new, 1'b0);
    end
    pdat = 1'b1;
  endtask

  task automatic t_reset();
    chk8("R1 reset", code_byte, 8'h00);
    chk1("R1 reset", code_new, 1'b0);
    cyc(150);
    chk8("R1 after idle", code_byte, 8'h00);
    chk1("R1 after idle", code_new, 1'b0);
  endtask

  task automatic t_good(input logic [7:0] d, input string tag);
    send_bits(mk(d, 0, 0, 0), 11, -1, 0);
    cyc(150);
    chk8(tag, code_byte, d);
    chk1(tag, code_new, 1'b1);
    last = d;
  endtask

  task automatic t_bad(input logic [11:0] bits, input int n, input string tag);
    send_bits(bits, n, -1, 0);
    cyc(150);
    chk8(tag, code_byte, last);
    chk1(tag, code_new, 1'b0);
  endtask

  task automatic t_mid();
    send_bits(mk(8'h6B, 0, 0, 0), 11, -1, 1);
    cyc(150);
    chk8("R8 after frame", code_byte, 8'h6B);
    last = 8'h6B;
  endtask

  task automatic t_glitch();
    send_bits(mk(8'hC3, 0, 0, 0), 11, 4, 0);
    cyc(150);
    chk8("R9 glitch", code_byte, 8'hC3);
    chk1("R9 glitch", code_new, 1'b1);
    last = 8'hC3;
  endtask

  task automatic t_idle();
    send_bits(mk(8'h2E, 0, 0, 0), 11, -1, 0);
    cyc(10);
    chk1("R10 before timeout", code_new, 1'b0);
    cyc(100);
    chk1("R10 after timeout", code_new, 1'b1);
    chk8("R10 after timeout", code_byte, 8'h2E);
    last = 8'h2E;
  endtask

  task automatic t_hold();
    cyc(600);
    chk1("R11 hold", code_new, 1'b1);
    chk8("R11 hold", code_byte, last);
  endtask

  initial begin
    checks = 0;
    errors = 0;
    last   = 8'h00;
    rst_n  = 1'b0;
    pclk   = 1'b1;
    pdat   = 1'b1;
    cyc(5);
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_good(8'h1C, "R2 byte 1C");
    t_good(8'hFF, "R2 byte FF");
    t_good(8'h80, "R3 msb");
    t_good(8'h01, "R3 lsb");
    t_bad(mk(8'h33, 0, 1, 0), 11, "R4 parity");
    t_bad(mk(8'h4D, 1, 0, 0), 11, "R5 start");
    t_bad(mk(8'h4D, 0, 0, 1), 11, "R6 stop");
    t_bad(mk(8'h77, 0, 0, 0), 10, "R7 short");
    t_bad(mk(8'h77, 0, 0, 0), 12, "R7 long");
    t_good(8'h5A, "R7 recovery");
    t_mid();
    t_glitch();
    t_idle();
    t_hold();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule